// File: doc/BRIEF.md
# Indirect Register Window for an Interrupt Routing Table

This block is the software-facing front end of a 24-pin interrupt router. A bus master reaches all internal state through two addresses: a select register that names one internal register, and a data window that reads or writes the named register. Behind the window are a version word, a 4-bit controller ID (which also has a read-only alias), and one 64-bit routing entry per interrupt pin. Each routing entry is reached as two 32-bit halves.

The whole routing table leaves the block as a flat vector, so that delivery logic can use it directly. Each accepted table write is reported one cycle later with the entry number. The report also carries a flag that says whether that pin was pending at the time, so that the pin can be evaluated again for delivery. Delivery logic marks an entry as in service through a set pulse. A software write to the low half of the entry clears that mark.

Top module: `irq_regwin_top`

## Requirements
- R1: After reset the select register and the ID are 0. Every entry holds 0x0000_0000_0001_0000, so only its mask bit 16 is set. No write event is reported.
- R2: The select register is at offset 0x00 and the window at offset 0x10. Only address bits 7:0 are decoded. The select register takes data bits 7:0 and reads back zero-extended.
- R3: Window select 0x00 reads the version word: PINS−1 in bits 23:16, the VERSION parameter in bits 7:0 and zero elsewhere. Writes to this select change nothing.
- R4: A window write with select 0x01 loads the ID from data bits 27:24. Selects 0x01 and 0x02 both read the ID in bits 27:24 and zero elsewhere. A write with select 0x02 changes nothing.
- R5: A select of 0x10 or above addresses entry (select−0x10)>>1. An even select accesses entry bits 31:0 and an odd select accesses bits 63:32.
- R6: A low-half write stores the data and forces the in-service flag, entry bit 14, to 0. A high-half write leaves bit 14 unchanged.
- R7: A pulse on inSvcSet[i] sets bit 14 of entry i. If the pulse arrives in the same cycle as a low-half write to that entry, the flag ends up set.
- R8: A window access whose entry index is PINS or more, or whose select is 0x03 to 0x0F, reads 0. Writes to such selects are discarded and produce no event.
- R9: A window write to a valid entry gives wrValid=1 for exactly the next cycle, with wrIdx set to the entry and retrig set to pendIn[entry] as sampled at the write edge. In every other cycle wrValid and retrig are 0.
- R10: Offsets other than 0x00 and 0x10 read 0, and writes to them have no effect.
- R11: tableFlat[i*64 +: 64] always holds entry i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Bus address; only bits 7:0 are decoded |
| wrEn | input | 1 | Write strobe for one cycle |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for addr |
| pendIn | input | PINS | Pending bit of each pin |
| inSvcSet | input | PINS | Sets the in-service flag of each entry |
| tableFlat | output | PINS*64 | All routing entries, entry i at bits i*64 upward |
| wrValid | output | 1 | An entry was written in the previous cycle |
| wrIdx | output | IDX_W | Number of the entry that was written |
| retrig | output | 1 | The written pin was pending |

## Verification
The bench targets the select arithmetic at its edges: select 0x03 to 0x0F, the last valid half (0x3F), and the first select past the table (0x40). A decoder that gets these wrong either aliases writes onto a real entry or reports events for entries that do not exist. The in-service flag is checked under a low-half write, a high-half write, and a set pulse that coincides with a low-half write. A design with the wrong side effect or the wrong precedence shows a bit 14 that differs when the entry is read back. The ID alias, the write-protected selects and the undecoded offsets are checked after writes to them, so a design that lets those writes through changes a read-back value. Random traffic with random pending bits checks that retrig and wrIdx follow the entry that was actually written.

// File: rtl/irq_regwin_pkg.sv
package irq_regwin_pkg;

  localparam logic [7:0] OFF_SEL  = 8'h00;
  localparam logic [7:0] OFF_WIN  = 8'h10;
  localparam logic [7:0] SEL_VER  = 8'h00;
  localparam logic [7:0] SEL_ID   = 8'h01;
  localparam logic [7:0] SEL_ARB  = 8'h02;
  localparam logic [7:0] SEL_TBL  = 8'h10;
  localparam int         INSVC_BIT = 14;
  localparam int         MASK_BIT  = 16;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_SEL,
    RD_VER,
    RD_ID,
    RD_LO,
    RD_HI
  } rdSrc_e;

  typedef struct packed {
    logic       selWr;
    logic       idWr;
    logic       loWr;
    logic       hiWr;
    logic [7:0] entry;
    rdSrc_e     rdSrc;
  } strobes_t;

endpackage

// File: rtl/irq_regwin_ctrl.sv
module irq_regwin_ctrl
  import irq_regwin_pkg::*;
#(
  parameter int PINS   = 24,
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [7:0]        selReg,
  output strobes_t          st
);

  logic [7:0] off;
  logic [7:0] rel;
  logic [7:0] entNum;
  logic       isTbl;
  logic       entOk;
  logic       atSel;
  logic       atWin;

  assign off    = addr[7:0];
  assign atSel  = (off == OFF_SEL);
  assign atWin  = (off == OFF_WIN);
  assign rel    = selReg - SEL_TBL;
  assign entNum = {1'b0, rel[7:1]};
  assign isTbl  = (selReg >= SEL_TBL);
  assign entOk  = isTbl && (32'(entNum) < PINS);

  always_comb begin
    st       = '0;
    st.entry = entNum;
    st.rdSrc = RD_ZERO;
    st.selWr = wrEn && atSel;
    if (atSel) begin
      st.rdSrc = RD_SEL;
    end else if (atWin) begin
      if (selReg == SEL_VER) begin
        st.rdSrc = RD_VER;
      end else if (selReg == SEL_ID || selReg == SEL_ARB) begin
        st.rdSrc = RD_ID;
      end else if (entOk) begin
        st.rdSrc = selReg[0] ? RD_HI : RD_LO;
      end
      st.idWr = wrEn && (selReg == SEL_ID);
      st.loWr = wrEn && entOk && !selReg[0];
      st.hiWr = wrEn && entOk && selReg[0];
    end
  end

endmodule

// File: rtl/irq_regwin_dp.sv
module irq_regwin_dp
  import irq_regwin_pkg::*;
#(
  parameter int         PINS    = 24,
  parameter logic [7:0] VERSION = 8'h11,
  localparam int        IDX_W   = $clog2(PINS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         st,
  input  logic [31:0]      wrData,
  input  logic [PINS-1:0]  pendIn,
  input  logic [PINS-1:0]  inSvcSet,
  output logic [7:0]       selReg,
  output logic [31:0]      rdData,
  output logic [PINS*64-1:0] tableFlat,
  output logic             wrValid,
  output logic [IDX_W-1:0] wrIdx,
  output logic             retrig
);

  localparam logic [7:0] LAST_PIN = 8'(PINS - 1);

  logic [3:0]       idReg;
  logic [IDX_W-1:0] curIdx;
  logic [63:0]      curEnt;

  assign curIdx = st.entry[IDX_W-1:0];
  assign curEnt = tableFlat[curIdx*64 +: 64];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
      idReg  <= '0;
    end else begin
      if (st.selWr) selReg <= wrData[7:0];
      if (st.idWr)  idReg  <= wrData[27:24];
    end
  end

  for (genvar g = 0; g < PINS; g++) begin : gEnt
    logic [63:0] ent;
    logic        hit;
    assign hit = (st.entry == 8'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ent <= 64'(1) << MASK_BIT;
      end else begin
        if (st.loWr && hit) begin
          ent[31:0]      <= wrData;
          ent[INSVC_BIT] <= 1'b0;
        end
        if (st.hiWr && hit) ent[63:32] <= wrData;
        if (inSvcSet[g]) ent[INSVC_BIT] <= 1'b1;
      end
    end
    assign tableFlat[g*64 +: 64] = ent;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrValid <= 1'b0;
      wrIdx   <= '0;
      retrig  <= 1'b0;
    end else begin
      wrValid <= st.loWr || st.hiWr;
      retrig  <= (st.loWr || st.hiWr) && pendIn[curIdx];
      if (st.loWr || st.hiWr) wrIdx <= curIdx;
    end
  end

  always_comb begin
    unique case (st.rdSrc)
      RD_SEL:  rdData = {24'h0, selReg};
      RD_VER:  rdData = {8'h00, LAST_PIN, 8'h00, VERSION};
      RD_ID:   rdData = {4'h0, idReg, 24'h0};
      RD_LO:   rdData = curEnt[31:0];
      RD_HI:   rdData = curEnt[63:32];
      default: rdData = 32'h0;
    endcase
  end

endmodule

// File: rtl/irq_regwin_top.sv
module irq_regwin_top
  import irq_regwin_pkg::*;
#(
  parameter int         PINS    = 24,
  parameter int         ADDR_W  = 12,
  parameter logic [7:0] VERSION = 8'h11,
  localparam int        IDX_W   = $clog2(PINS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wrEn,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  input  logic [PINS-1:0]    pendIn,
  input  logic [PINS-1:0]    inSvcSet,
  output logic [PINS*64-1:0] tableFlat,
  output logic               wrValid,
  output logic [IDX_W-1:0]   wrIdx,
  output logic               retrig
);

  strobes_t   st;
  logic [7:0] selReg;

  irq_regwin_ctrl #(.PINS(PINS), .ADDR_W(ADDR_W)) uCtrl (
    .addr(addr), .wrEn(wrEn), .selReg(selReg), .st(st)
  );

  irq_regwin_dp #(.PINS(PINS), .VERSION(VERSION)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData), .pendIn(pendIn),
    .inSvcSet(inSvcSet), .selReg(selReg), .rdData(rdData),
    .tableFlat(tableFlat), .wrValid(wrValid), .wrIdx(wrIdx), .retrig(retrig)
  );

endmodule

// File: rtl/irq_regwin_chk.sv
module irq_regwin_chk #(
  parameter int PINS   = 24,
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  addr,
  input logic               wrEn,
  input logic [31:0]        rdData,
  input logic [PINS-1:0]    inSvcSet,
  input logic [PINS*64-1:0] tableFlat,
  input logic               wrValid,
  input logic [IDX_W-1:0]   wrIdx,
  input logic               retrig
);

  // R9: retrig only accompanies a write event
  a_r9_retrig_with_event: assert property (@(posedge clk) disable iff (!rstN)
    retrig |-> wrValid);

  // R9: an event follows a window write
  a_r9_event_cause: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> $past(wrEn && addr[7:0] == 8'h10));

  // R8: reported entry is always a real one
  a_r8_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (32'(wrIdx) < PINS));

  // R10: no window write and no set pulse leaves the table unchanged
  a_r10_table_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!(wrEn && addr[7:0] == 8'h10) && inSvcSet == '0) |=> $stable(tableFlat));

  // R10: undecoded offsets read zero
  a_r10_other_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr[7:0] != 8'h00 && addr[7:0] != 8'h10) |-> rdData == 32'h0);

endmodule

bind irq_regwin_top irq_regwin_chk #(.PINS(PINS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdData(rdData),
  .inSvcSet(inSvcSet), .tableFlat(tableFlat), .wrValid(wrValid),
  .wrIdx(wrIdx), .retrig(retrig)
);

// File: tb/irq_regwin_top_test.sv
`timescale 1ns/1ps
module irq_regwin_top_test;
  localparam int PINS = 24;
  localparam int ADDR_W = 12;
  localparam int IDX_W = 5;
  localparam logic [7:0] VERSION = 8'h11;

  logic clk = 0, rstN = 0, wrEn = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wrData = '0, rdData;
  logic [PINS-1:0] pendIn = '0, inSvcSet = '0;
  logic [PINS*64-1:0] tableFlat;
  logic wrValid, retrig;
  logic [IDX_W-1:0] wrIdx;

  int nChk = 0, nFail = 0;
  logic [7:0] mSel;
  logic [3:0] mId;
  logic [63:0] mTbl [PINS];

  always #4 clk = ~clk;

  irq_regwin_top #(.PINS(PINS), .ADDR_W(ADDR_W), .VERSION(VERSION)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .pendIn(pendIn), .inSvcSet(inSvcSet), .tableFlat(tableFlat),
    .wrValid(wrValid), .wrIdx(wrIdx), .retrig(retrig)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit entValid(input logic [7:0] s);
    return s >= 8'h10 && ((s - 8'h10) >> 1) < PINS;
  endfunction

  function automatic logic [31:0] expRd(input logic [7:0] off);
    logic [63:0] e;
    if (off == 8'h00) return {24'h0, mSel};
    if (off != 8'h10) return 32'h0;
    if (mSel == 8'h00) return {8'h0, 8'(PINS - 1), 8'h0, VERSION};
    if (mSel == 8'h01 || mSel == 8'h02) return {4'h0, mId, 24'h0};
    if (!entValid(mSel)) return 32'h0;
    e = mTbl[(mSel - 8'h10) >> 1];
    return mSel[0] ? e[63:32] : e[31:0];
  endfunction

  task automatic rd(input logic [ADDR_W-1:0] a, input string req);
    logic [31:0] exp;
    @(negedge clk);
    addr = a; wrEn = 0;
    #1;
    exp = expRd(a[7:0]);
    chk(rdData === exp, req, 64'(rdData), 64'(exp));
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input string req);
    bit ev;
    int idx;
    logic expRt;
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1;
    ev = (a[7:0] == 8'h10) && entValid(mSel);
    idx = ev ? int'((mSel - 8'h10) >> 1) : 0;
    expRt = ev && pendIn[idx];
    @(negedge clk);
    wrEn = 0;
    chk(wrValid === ev, req, 64'(wrValid), 64'(ev));
    if (ev) chk(wrIdx === IDX_W'(idx), "R9 idx", 64'(wrIdx), 64'(idx));
    chk(retrig === expRt, "R9 retrig", 64'(retrig), 64'(expRt));
    if (a[7:0] == 8'h00) mSel = d[7:0];
    else if (a[7:0] == 8'h10) begin
      if (mSel == 8'h01) mId = d[27:24];
      else if (ev) begin
        if (mSel[0]) mTbl[idx][63:32] = d;
        else begin mTbl[idx][31:0] = d; mTbl[idx][14] = 1'b0; end
      end
    end
  endtask

  task automatic svc(input logic [PINS-1:0] m);
    @(negedge clk);
    inSvcSet = m;
    @(negedge clk);
    inSvcSet = '0;
    for (int i = 0; i < PINS; i++) if (m[i]) mTbl[i][14] = 1'b1;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    mSel = 0; mId = 0;
    for (int i = 0; i < PINS; i++) mTbl[i] = 64'h1_0000;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    @(negedge clk);
    chk(wrValid === 0, "R1 no event", 64'(wrValid), 0);
    for (int i = 0; i < PINS; i++)
      chk(tableFlat[i*64 +: 64] === 64'h1_0000, "R1 entry mask", tableFlat[i*64 +: 64], 64'h1_0000);
    rd(12'h000, "R1 R2 select zero");
    rd(12'h010, "R1 R3 version");
    // R2 upper address bits ignored
    wr(12'hA00, 32'hFFFF_FF01, "R2 select write");
    rd(12'h300, "R2 select readback");
    // R4 ID
    wr(12'h010, 32'h5A00_0000, "R4 id write");
    rd(12'h010, "R4 id read");
    wr(12'h000, 32'h02, "R2"); wr(12'h010, 32'hF000_0000, "R4 arb write ignored");
    rd(12'h010, "R4 arb alias");
    // R3 version write ignored
    wr(12'h000, 32'h00, "R2"); wr(12'h010, 32'hFFFF_FFFF, "R3 ver write");
    rd(12'h010, "R3 version unchanged");
    // R8 reserved selects
    wr(12'h000, 32'h07, "R2"); wr(12'h010, 32'hFFFF_FFFF, "R8 reserved write");
    rd(12'h010, "R8 reserved read");
    wr(12'h000, 32'h40, "R2"); wr(12'h010, 32'hFFFF_FFFF, "R8 past table");
    rd(12'h010, "R8 past table read");
    // R5 last entry high half
    pendIn = 24'h80_0000;
    wr(12'h000, 32'h3F, "R2"); wr(12'h010, 32'hC3C3_0000, "R5 R9 last high");
    rd(12'h010, "R5 last high read");
    chk(tableFlat[23*64 + 32 +: 32] === 32'hC3C3_0000, "R11 export", tableFlat[23*64+32 +: 32], 64'hC3C3_0000);
    // R6 R7 in-service flag
    svc(24'h00_0004);
    wr(12'h000, 32'h15, "R2"); wr(12'h010, 32'h1234_5678, "R6 high keeps flag");
    wr(12'h000, 32'h14, "R2"); rd(12'h010, "R6 flag still set");
    wr(12'h010, 32'h0000_40FF, "R6 low clears flag");
    rd(12'h010, "R6 flag cleared");
    // R7 same-cycle set wins
    @(negedge clk);
    addr = 12'h010; wrData = 32'h0000_0033; wrEn = 1; inSvcSet = 24'h00_0004;
    @(negedge clk);
    wrEn = 0; inSvcSet = '0;
    mTbl[2][31:0] = 32'h0000_4033;
    rd(12'h010, "R7 set wins");
    // R10 other offsets
    wr(12'h004, 32'hFFFF_FFFF, "R10 other write");
    rd(12'h020, "R10 other read");
    rd(12'h000, "R10 select untouched");
    // random traffic
    for (int n = 0; n < 600; n++) begin
      logic [ADDR_W-1:0] a;
      int k;
      pendIn = PINS'($urandom);
      k = int'($urandom_range(0, 9));
      a = ADDR_W'($urandom) & 12'hF00;
      if (k < 3) wr(a | 12'h000, 32'($urandom_range(0, 8'h44)), "R2 R5 rand sel");
      else if (k < 6) wr(a | 12'h010, $urandom, "R5 R6 R9 rand write");
      else if (k < 8) rd(a | 12'h010, "R5 rand read");
      else if (k == 8) svc(PINS'($urandom));
      else rd(a | ADDR_W'($urandom_range(0, 255)), "R10 R2 rand off");
    end
    for (int i = 0; i < PINS; i++)
      chk(tableFlat[i*64 +: 64] === mTbl[i], "R11 final table", tableFlat[i*64 +: 64], mTbl[i]);
    summary();
  end
endmodule